// File: doc/BRIEF.md
# Nibble Command/Response Responder

This block answers a four-bit command bus that is shared in both directions and paced by a two-wire, four-phase handshake. The external master puts a command nibble on the shared lines and raises its request line. The block synchronises both, takes the nibble, and picks one of several internal result sources by command code. It then turns the bus around: it enables its drivers with the result and raises acknowledge. Result and acknowledge stay up until the master lowers its request. The block then drops acknowledge, releases the lines and waits for the next command.

The pad side is split into an input nibble, an output nibble and an output enable, so the chip's pad ring builds the tri-state buffer. A hold input is raised while the FPGA fabric is being reprogrammed. While it is high, the drivers are turned off at once and the controller is parked in its idle state. The block runs from its system clock (50 MHz in the target system) and treats the request and the data nibble as asynchronous.

Top module: `nib_cmd_responder`

## Requirements
- R1: While reset is low, and on the first cycle after it, `ack_out` and `bus_oe` are 0.
- R2: When `req_in` and a command on `bus_in` are set up before a rising clock edge E0 and held, `ack_out` and `bus_oe` stay 0 through edge E3 and are both 1 after edge E4.
- R3: The command is the value of `bus_in` taken through two synchroniser flops and latched one cycle after the synchronised request is first seen high. Changing `bus_in` after edge E2 does not alter the response.
- R4: Command code 1 returns `src_a`, code 2 returns `src_b` and code 3 returns `status_in`, on `bus_out` with `bus_oe` high. The sources are sampled at edge E4.
- R5: Every other command code (0 and 4 to 15) returns 15 (all ones).
- R6: While `ack_out` is high, `bus_out` keeps its value, even when the result sources change.
- R7: When `req_in` falls before an edge F0 during acknowledge, `ack_out` and `bus_oe` stay 1 after F0 and F1 and are 0 after F2. A new transaction can then follow.
- R8: While `prog_hold` is 1, `bus_oe` and `ack_out` are 0 in the same cycle and the controller is held in idle, so a request raised during the hold produces no acknowledge.
- R9: `bus_oe` is never 1 while `ack_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_hold | input | 1 | High while the fabric is being reprogrammed; releases the bus and idles the controller |
| req_in | input | 1 | Master request line, asynchronous |
| bus_in | input | 4 | Shared bus as seen at the pad input, asynchronous |
| bus_out | output | 4 | Response nibble to the pad driver (0 when not driving) |
| bus_oe | output | 1 | Pad driver enable for the shared bus |
| ack_out | output | 1 | Acknowledge to the master |
| src_a | input | 4 | Result source selected by command 1 |
| src_b | input | 4 | Result source selected by command 2 |
| status_in | input | 4 | Status nibble selected by command 3 |

## Verification
With the request set up before edge E0, acknowledge and the result are due after edge E4. That delay is two synchroniser flops, one idle-to-settle step, the latch and the result load. After the request falls, the release is due after the third edge. The bench drives on the falling clock edge and counts rising edges from that point. It samples just after the edge where each output is due and also one edge earlier, so it catches a result that arrives early or late. The hold input acts through combinational gating, so its check is made in the same cycle, before any clock edge.

// File: rtl/nib_pkg.sv
// Shared types and command codes for the nibble responder.
// Assumes command codes fit in the bus width used by the instantiating block.
package nib_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_PROC   = 2'd2,
        ST_RESP   = 2'd3
    } nib_state_e;

    // Command codes that select an internal source
    localparam int CMD_SRC_A  = 1;
    localparam int CMD_SRC_B  = 2;
    localparam int CMD_STATUS = 3;

endpackage

// File: rtl/nib_sync.sv
// Multi-stage synchroniser for a group of asynchronous inputs.
// Assumes the bits of the group may be taken independently (each bit is
// only used after the group has been still for at least one cycle).
module nib_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous group through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/nib_decode.sv
// Command decoder: selects which internal source answers a command.
// Purely combinational; unknown codes answer with all ones.
module nib_decode
    import nib_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] cmd,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] result
);

    localparam logic [DATA_W-1:0] CODE_A  = DATA_W'(CMD_SRC_A);
    localparam logic [DATA_W-1:0] CODE_B  = DATA_W'(CMD_SRC_B);
    localparam logic [DATA_W-1:0] CODE_ST = DATA_W'(CMD_STATUS);

    // Pick the result source for the latched command
    always_comb begin
        if (cmd == CODE_A)       result = src_a;
        else if (cmd == CODE_B)  result = src_b;
        else if (cmd == CODE_ST) result = status_in;
        else                     result = '1;
    end

endmodule

// File: rtl/nib_fsm.sv
// Four-phase handshake controller. Waits one cycle after the synchronised
// request rises, latches the command, loads the result, then acknowledges
// until the request falls. Assumes req_sync is already synchronised and
// hold is synchronous to clk.
module nib_fsm
    import nib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       req_sync,
    output nib_state_e state,
    output logic       latch_cmd,
    output logic       load_res,
    output logic       responding
);

    nib_state_e state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_sync)  state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_PROC;
            ST_PROC:   state_nx = ST_RESP;
            ST_RESP:   if (!req_sync) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (hold) state_nx = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign latch_cmd  = (state == ST_SETTLE) && !hold;
    assign load_res   = (state == ST_PROC) && !hold;
    assign responding = (state == ST_RESP) && !hold;

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == ST_IDLE));

    // R3
    settle_to_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !hold) |=> (state == ST_PROC));

    // R7
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP && !req_sync) |=> (state == ST_IDLE));

endmodule

// File: rtl/nib_cmd_responder.sv
// Top of the nibble command/response responder. Synchronises the request
// and data nibble, latches the command, decodes it into a registered result
// and drives it on the shared bus under the handshake. Assumes the pad ring
// builds the tri-state buffer from bus_out/bus_oe and that prog_hold is
// synchronous to clk.
module nib_cmd_responder
    import nib_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_hold,
    input  logic              req_in,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              ack_out,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] status_in
);

    localparam int SYNC_W = DATA_W + 1;

    logic [SYNC_W-1:0] sync_q;
    logic              req_sync;
    logic [DATA_W-1:0] data_sync;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] res_q;
    logic              latch_cmd;
    logic              load_res;
    logic              responding;
    nib_state_e        state;

    nib_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({req_in, bus_in}),
        .q_sync  (sync_q)
    );

    assign req_sync  = sync_q[SYNC_W-1];
    assign data_sync = sync_q[DATA_W-1:0];

    nib_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (prog_hold),
        .req_sync   (req_sync),
        .state      (state),
        .latch_cmd  (latch_cmd),
        .load_res   (load_res),
        .responding (responding)
    );

    nib_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd       (cmd_q),
        .src_a     (src_a),
        .src_b     (src_b),
        .status_in (status_in),
        .result    (res_d)
    );

    // Capture the command and the decoded result at their phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            res_q <= '0;
        end else begin
            if (latch_cmd) cmd_q <= data_sync;
            if (load_res)  res_q <= res_d;
        end
    end

    assign ack_out = responding;
    assign bus_oe  = responding;
    assign bus_out = responding ? res_q : '0;

    // R6
    resp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && $past(ack_out)) |-> $stable(bus_out));

    // R9
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ack_out);

    // R2
    ack_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> ($past(state) == ST_PROC));

endmodule

// File: tb/nib_cmd_responder_bench.sv
// Sweep bench: every command code with several source patterns, timing of
// acknowledge rise and fall, bus changes after capture, and the hold input.
module nib_cmd_responder_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       prog_hold;
    logic       req_in;
    logic [3:0] bus_in;
    logic [3:0] bus_out;
    logic       bus_oe;
    logic       ack_out;
    logic [3:0] src_a;
    logic [3:0] src_b;
    logic [3:0] status_in;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nib_cmd_responder u_nib_cmd_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_hold (prog_hold),
        .req_in    (req_in),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .ack_out   (ack_out),
        .src_a     (src_a),
        .src_b     (src_b),
        .status_in (status_in)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model(input logic [3:0] c, input logic [3:0] a,
                                         input logic [3:0] b, input logic [3:0] s);
        if (c == 4'd1) return a;
        if (c == 4'd2) return b;
        if (c == 4'd3) return s;
        return 4'hF;
    endfunction

    // One full transaction; inputs driven at a falling edge
    task automatic transact(input logic [3:0] c, input logic [3:0] a,
                            input logic [3:0] b, input logic [3:0] s);
        logic [3:0] exp_v;
        exp_v = model(c, a, b, s);
        @(negedge clk);
        bus_in = c; req_in = 1'b1; src_a = a; src_b = b; status_in = s;
        repeat (3) @(posedge clk);
        #1 bus_in = ~c;                               // R3 change after E2
        @(posedge clk); #1;                           // after E3
        chk("R2 ack early", {7'd0, ack_out}, 8'd0);
        @(posedge clk); #1;                           // after E4
        chk("R2 ack due", {6'd0, ack_out, bus_oe}, 8'd3);
        if (c inside {4'd1, 4'd2, 4'd3})
            chk("R4 selected source", {4'd0, bus_out}, {4'd0, exp_v});
        else
            chk("R5 unknown code", {4'd0, bus_out}, {4'd0, exp_v});
        src_a = ~a; src_b = ~b; status_in = ~s;
        repeat (2) @(posedge clk); #1;
        chk("R6 held result", {3'd0, ack_out, bus_out}, {3'd0, 1'b1, exp_v});
        @(negedge clk);
        req_in = 1'b0;
        repeat (2) @(posedge clk); #1;                // after F1
        chk("R7 ack still up", {6'd0, ack_out, bus_oe}, 8'd3);
        @(posedge clk); #1;                           // after F2
        chk("R7 released", {6'd0, ack_out, bus_oe}, 8'd0);
        chk("R9 oe with ack", {7'd0, bus_oe & ~ack_out}, 8'd0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        rst_n = 1'b0; prog_hold = 1'b0; req_in = 1'b0; bus_in = 4'd0;
        src_a = 4'd0; src_b = 4'd0; status_in = 4'd0;
        repeat (3) @(posedge clk); #1;
        chk("R1 reset outputs", {6'd0, ack_out, bus_oe}, 8'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", {6'd0, ack_out, bus_oe}, 8'd0);

        // R4 R5: sweep every code with several source patterns
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 16; c++) begin
                transact(4'(c), 4'(3 + p * 5), 4'(9 - p * 2), 4'(12 ^ p));
            end
        end

        // R8: hold during acknowledge
        @(negedge clk);
        bus_in = 4'd2; req_in = 1'b1; src_b = 4'h6;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R8 pre-hold ack", {7'd0, ack_out}, 8'd1);
        prog_hold = 1'b1; #1;
        chk("R8 hold same cycle", {6'd0, ack_out, bus_oe}, 8'd0);
        repeat (8) @(posedge clk); #1;
        chk("R8 request ignored", {6'd0, ack_out, bus_oe}, 8'd0);
        @(negedge clk); req_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); prog_hold = 1'b0;
        repeat (8) @(posedge clk); #1;
        chk("R8 quiet after hold", {6'd0, ack_out, bus_oe}, 8'd0);

        // R8: request raised during hold gives no acknowledge
        @(negedge clk); prog_hold = 1'b1; req_in = 1'b1; bus_in = 4'd1;
        repeat (10) @(posedge clk); #1;
        chk("R8 no ack while held", {7'd0, ack_out}, 8'd0);
        @(negedge clk); req_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); prog_hold = 1'b0;

        // R7: a clean transaction after the hold
        transact(4'd3, 4'd0, 4'd0, 4'hA);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule